// File: doc/BRIEF.md
# Asynchronous Error Trap Status Logic

This block sits beside a processor's trap logic and decides, cycle by cycle, whether incoming uncorrectable-error indications should raise a single-error trap or a multiple-error trap. The choice is made by a handler-mode control bit. While that bit is low, instruction-side and asynchronous uncorrectable errors lead to a single-error trap. While it is high, an instruction uncorrectable error, an instruction access error or a data access error leads to a multiple-error trap instead.

On every trap the block updates a 64-bit read-only status word. A single trap records three things: how the trapped instruction ends, the privilege level held just before the trap, and cleared cause bits. A multiple trap sets the cause bit of each source present in that event and leaves the other cause bits as they were. The word is visible on a port and can also be fetched through a one-cycle read port. Error detection, trap vector calculation and trap-level handling are done elsewhere.

Top module: `aet_trap_status`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, at the next edge the status word becomes 0, rd_valid becomes 0, and no trap pulse is raised, even when error inputs are active in that cycle.
- R2: With handler_mode at 0, err_iuge or err_auge sampled high at a rising edge makes trap_single high for exactly the following cycle. In every cycle with no trap pulse, the status word is unchanged from the previous cycle.
- R3: With handler_mode at 1, any of err_iuge, err_iacc or err_dacc sampled high makes trap_multi high for exactly the following cycle. trap_single and trap_multi are never high together.
- R4: Error inputs outside the selected mode raise no trap and leave the status word unchanged. This covers err_iacc or err_dacc without an uncorrectable error while handler_mode is 0, and err_auge alone while handler_mode is 1.
- R5: On a single trap, status bits 5:4 take end_method (00 precise, 01 retryable but not precise, 11 not retryable). If wdog_timeout is high in the same cycle, they take 10 instead.
- R6: On a single trap, status bit 3 becomes 1 when priv_bad is high. Otherwise it becomes a copy of priv_in.
- R7: On a single trap, status bits 2 (data access cause), 1 (instruction access cause) and 0 (instruction uncorrectable cause) are all cleared to 0.
- R8: On a multiple trap, bit 2 is set if err_dacc is present, bit 1 if err_iacc is present, and bit 0 if err_iuge is present. Each cause bit whose source is absent keeps its value, and bits 5:3 are unchanged.
- R9: Status bits 63:6 always read 0.
- R10: rd_en sampled high at an edge makes rd_valid high for the following cycle only. In that cycle rd_data holds the status word as it stood just before that edge, so a trap at the same edge is not yet included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| handler_mode | input | 1 | 0 selects single-error traps, 1 selects multiple-error traps |
| err_iuge | input | 1 | Instruction-side uncorrectable error pulse |
| err_auge | input | 1 | Asynchronous uncorrectable error pulse |
| err_iacc | input | 1 | Instruction access error pulse |
| err_dacc | input | 1 | Data access error pulse |
| end_method | input | 2 | End-method code of the trapped instruction |
| wdog_timeout | input | 1 | Watchdog timeout seen with this event |
| priv_in | input | 1 | Privilege bit held before the trap |
| priv_bad | input | 1 | Privilege bit is corrupted by an uncorrectable error |
| rd_en | input | 1 | Read request for the status word |
| trap_single | output | 1 | Single-error trap request pulse |
| trap_multi | output | 1 | Multiple-error trap request pulse |
| status_word | output | 64 | Current status word |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Status word returned by a read |

## Verification
The hardest case to reach is a multiple trap that has to prove the cause bits are sticky. This needs cause bits already set by an earlier multiple trap with a different source, and it needs bits 5:3 left non-zero by an earlier single trap, so that "unchanged" can be told apart from "cleared". The stimulus therefore runs a fixed chain: first a single trap with a non-zero end-method and the privilege bit set, then multiple traps with one cause each, building up the cause bits one at a time. After that comes a single trap that must clear them, and then a read issued in the same cycle as a trap, which must return the older word.

// File: rtl/aet_pkg.sv
package aet_pkg;
  localparam int NCAUSE     = 3;
  localparam int CAUSE_IUGE = 0;
  localparam int CAUSE_IACC = 1;
  localparam int CAUSE_DACC = 2;
  localparam int PRIV_POS   = 3;
  localparam int EM_LO      = 4;
  localparam int EM_W       = 2;
  localparam int USED_W     = EM_LO + EM_W;

  typedef enum logic [EM_W-1:0] {
    EM_PRECISE = 2'b00,
    EM_RETRY   = 2'b01,
    EM_UNDEF   = 2'b10,
    EM_NORETRY = 2'b11
  } end_method_e;
endpackage

// File: rtl/aet_classify.sv
module aet_classify
  import aet_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              iuge,
  input  logic              auge,
  input  logic              iacc,
  input  logic              dacc,
  output logic              single_hit,
  output logic              multi_hit,
  output logic [NCAUSE-1:0] cause_vec,
  output logic              trap_single_q,
  output logic              trap_multi_q
);
  logic single_src;
  logic multi_src;

  always_comb begin
    cause_vec             = '0;
    cause_vec[CAUSE_IUGE] = iuge;
    cause_vec[CAUSE_IACC] = iacc;
    cause_vec[CAUSE_DACC] = dacc;
    single_src = iuge | auge;
    multi_src  = |cause_vec;
    single_hit = !rst && !mode && single_src;
    multi_hit  = !rst &&  mode && multi_src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_single_q <= 1'b0;
      trap_multi_q  <= 1'b0;
    end else begin
      trap_single_q <= single_hit;
      trap_multi_q  <= multi_hit;
    end
  end

  AST_SINGLE_MODE: assert property (@(posedge clk) disable iff (rst)
    trap_single_q |-> !$past(mode)); // R2
  AST_MULTI_MODE: assert property (@(posedge clk) disable iff (rst)
    trap_multi_q |-> $past(mode)); // R3
endmodule

// File: rtl/aet_status_reg.sv
module aet_status_reg
  import aet_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_hit,
  input  logic              multi_hit,
  input  logic [NCAUSE-1:0] cause_in,
  input  logic [EM_W-1:0]   end_method,
  input  logic              wdog,
  input  logic              priv,
  input  logic              priv_bad,
  output logic [STAT_W-1:0] status_word
);
  localparam int RESV_W = STAT_W - USED_W;

  logic [EM_W-1:0]   em_q;
  logic              priv_q;
  logic [NCAUSE-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      em_q   <= EM_PRECISE;
      priv_q <= 1'b0;
    end else if (single_hit) begin
      em_q   <= wdog ? EM_UNDEF : end_method;
      priv_q <= priv_bad | priv;
    end
  end

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst)                           cause_q[i] <= 1'b0;
      else if (single_hit)               cause_q[i] <= 1'b0;
      else if (multi_hit && cause_in[i]) cause_q[i] <= 1'b1;
    end
  end

  assign status_word = {{RESV_W{1'b0}}, em_q, priv_q, cause_q};

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_word[STAT_W-1:USED_W] == '0); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !single_hit && !multi_hit |=> $stable(status_word)); // R2
endmodule

// File: rtl/aet_rd_port.sv
module aet_rd_port #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] word_in,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_in;
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en)); // R10
  AST_RD_MATCH: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data == $past(word_in)); // R10
endmodule

// File: rtl/aet_trap_status.sv
module aet_trap_status
  import aet_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              handler_mode,
  input  logic              err_iuge,
  input  logic              err_auge,
  input  logic              err_iacc,
  input  logic              err_dacc,
  input  logic [1:0]        end_method,
  input  logic              wdog_timeout,
  input  logic              priv_in,
  input  logic              priv_bad,
  input  logic              rd_en,
  output logic              trap_single,
  output logic              trap_multi,
  output logic [STAT_W-1:0] status_word,
  output logic              rd_valid,
  output logic [STAT_W-1:0] rd_data
);
  logic              single_hit;
  logic              multi_hit;
  logic [NCAUSE-1:0] cause_vec;

  aet_classify u_classify (
    .clk          (clk),
    .rst          (rst),
    .mode         (handler_mode),
    .iuge         (err_iuge),
    .auge         (err_auge),
    .iacc         (err_iacc),
    .dacc         (err_dacc),
    .single_hit   (single_hit),
    .multi_hit    (multi_hit),
    .cause_vec    (cause_vec),
    .trap_single_q(trap_single),
    .trap_multi_q (trap_multi)
  );

  aet_status_reg #(.STAT_W(STAT_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .single_hit (single_hit),
    .multi_hit  (multi_hit),
    .cause_in   (cause_vec),
    .end_method (end_method),
    .wdog       (wdog_timeout),
    .priv       (priv_in),
    .priv_bad   (priv_bad),
    .status_word(status_word)
  );

  aet_rd_port #(.W(STAT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .word_in (status_word),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(trap_single && trap_multi)); // R3
  AST_IGNORE_OFFMODE: assert property (@(posedge clk) disable iff (rst)
    $past(!handler_mode && !err_iuge && !err_auge) |-> !trap_single && !trap_multi); // R4
  AST_WDOG_CODE: assert property (@(posedge clk) disable iff (rst)
    trap_single && $past(wdog_timeout) |-> status_word[5:4] == 2'b10); // R5
  AST_PRIV_BAD: assert property (@(posedge clk) disable iff (rst)
    trap_single && $past(priv_bad) |-> status_word[3]); // R6
  AST_SINGLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    trap_single |-> status_word[2:0] == 3'b000); // R7
  AST_MULTI_STICKY: assert property (@(posedge clk) disable iff (rst)
    trap_multi |-> (status_word[2:0] & $past(status_word[2:0])) == $past(status_word[2:0])); // R8
  AST_MULTI_UPPER: assert property (@(posedge clk) disable iff (rst)
    trap_multi |-> status_word[5:3] == $past(status_word[5:3])); // R8
endmodule

// File: tb/sim_aet_trap_status.sv
module sim_aet_trap_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        handler_mode = 1'b0;
  logic        err_iuge = 1'b0, err_auge = 1'b0, err_iacc = 1'b0, err_dacc = 1'b0;
  logic [1:0]  end_method = 2'b00;
  logic        wdog_timeout = 1'b0, priv_in = 1'b0, priv_bad = 1'b0, rd_en = 1'b0;
  logic        trap_single, trap_multi, rd_valid;
  logic [63:0] status_word, rd_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_w = '0;

  always #4 clk = ~clk;

  aet_trap_status u0 (
    .clk(clk), .rst(rst), .handler_mode(handler_mode),
    .err_iuge(err_iuge), .err_auge(err_auge), .err_iacc(err_iacc), .err_dacc(err_dacc),
    .end_method(end_method), .wdog_timeout(wdog_timeout), .priv_in(priv_in),
    .priv_bad(priv_bad), .rd_en(rd_en), .trap_single(trap_single),
    .trap_multi(trap_multi), .status_word(status_word), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_in();
    err_iuge = 0; err_auge = 0; err_iacc = 0; err_dacc = 0;
    wdog_timeout = 0; priv_in = 0; priv_bad = 0; end_method = 2'b00; rd_en = 0;
  endtask

  // one event: drive at falling edge, sample one cycle later at the next falling edge
  task automatic event_cyc(input logic m, input logic iu, input logic au, input logic ia,
                           input logic da, input logic [1:0] em, input logic wd,
                           input logic pv, input logic pb);
    @(negedge clk);
    handler_mode = m; err_iuge = iu; err_auge = au; err_iacc = ia; err_dacc = da;
    end_method = em; wdog_timeout = wd; priv_in = pv; priv_bad = pb;
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    rst = 1;
    @(negedge clk);
    handler_mode = 0; err_iuge = 1; err_auge = 1;
    @(negedge clk);
    chk("R1 trap_single in reset", {63'd0, trap_single}, 64'd0);
    chk("R1 trap_multi in reset", {63'd0, trap_multi}, 64'd0);
    chk("R1 status in reset", status_word, 64'd0);
    chk("R1 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    clear_in();
    rst = 0;
    @(negedge clk);
    exp_w = '0;
  endtask

  task automatic t_single_basic();
    event_cyc(0, 1, 0, 0, 0, 2'b01, 0, 1, 0);
    exp_w = 64'h18;
    chk("R2 single pulse", {62'd0, trap_single, trap_multi}, 64'd2);
    chk("R5 R6 single status", status_word, exp_w);
    @(negedge clk);
    chk("R2 single pulse one cycle", {62'd0, trap_single, trap_multi}, 64'd0);
    chk("R2 status holds when quiet", status_word, exp_w);
  endtask

  task automatic t_multi_chain();
    event_cyc(1, 0, 0, 1, 0, 2'b00, 0, 0, 0);
    exp_w = 64'h1A;
    chk("R3 multi pulse iacc", {62'd0, trap_single, trap_multi}, 64'd1);
    chk("R8 iacc cause set, 5:3 kept", status_word, exp_w);
    event_cyc(1, 0, 0, 0, 1, 2'b11, 1, 0, 1);
    exp_w = 64'h1E;
    chk("R8 dacc sticky with iacc", status_word, exp_w);
    event_cyc(1, 1, 0, 0, 0, 2'b00, 0, 0, 0);
    exp_w = 64'h1F;
    chk("R3 multi pulse iuge", {62'd0, trap_single, trap_multi}, 64'd1);
    chk("R8 iuge cause set, others kept", status_word, exp_w);
  endtask

  task automatic t_ignored();
    event_cyc(0, 0, 0, 1, 1, 2'b11, 0, 0, 1);
    chk("R4 access error in mode 0 no trap", {62'd0, trap_single, trap_multi}, 64'd0);
    chk("R4 access error in mode 0 status kept", status_word, exp_w);
    event_cyc(1, 0, 1, 0, 0, 2'b11, 0, 0, 1);
    chk("R4 async error in mode 1 no trap", {62'd0, trap_single, trap_multi}, 64'd0);
    chk("R4 async error in mode 1 status kept", status_word, exp_w);
  endtask

  task automatic t_single_clears();
    event_cyc(0, 0, 1, 1, 0, 2'b11, 0, 0, 1);
    exp_w = 64'h38;
    chk("R7 single clears causes", status_word, exp_w);
    chk("R2 single from async error", {62'd0, trap_single, trap_multi}, 64'd2);
    event_cyc(0, 1, 0, 0, 0, 2'b11, 1, 0, 0);
    exp_w = 64'h20;
    chk("R5 watchdog writes 10, R6 priv copy 0", status_word, exp_w);
    event_cyc(0, 1, 0, 0, 0, 2'b00, 0, 0, 0);
    exp_w = 64'h00;
    chk("R5 precise code", status_word, exp_w);
    chk("R9 upper bits zero", {status_word[63:6], 6'd0}, 64'd0);
  endtask

  task automatic t_read();
    @(negedge clk);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk("R10 rd_valid", {63'd0, rd_valid}, 64'd1);
    chk("R10 rd_data", rd_data, exp_w);
    @(negedge clk);
    chk("R10 rd_valid single cycle", {63'd0, rd_valid}, 64'd0);
    @(negedge clk);
    handler_mode = 1; err_dacc = 1; rd_en = 1;
    @(negedge clk);
    clear_in();
    chk("R10 read with trap returns older word", rd_data, exp_w);
    exp_w = 64'h04;
    chk("R8 status after colliding trap", status_word, exp_w);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst = 1; handler_mode = 1; err_iuge = 1; err_iacc = 1;
    @(negedge clk);
    chk("R1 reset suppresses trap", {62'd0, trap_single, trap_multi}, 64'd0);
    chk("R1 reset clears status", status_word, 64'd0);
    clear_in();
    rst = 0;
    exp_w = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single_basic();
    t_multi_chain();
    t_ignored();
    t_single_clears();
    t_read();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule